// File: doc/BRIEF.md
# Two-Port Mailbox Doorbell Flags

This block sits next to a shared two-sided memory and turns mailbox traffic into doorbell interrupts. It watches the control pins of both sides (select, read/write, output enable, address and busy) and keeps one active-low interrupt line per side. The two highest word addresses of the memory act as mailboxes. The left side's mailbox is the word one below the top. The right side's mailbox is the top word.

When one side writes the other side's mailbox, the interrupt of the receiving side goes low. When the receiving side later reads its own mailbox, its interrupt returns high. The 16-bit message itself stays in the memory array, which lies outside this block. The block never alters memory behaviour. If software does not use the doorbells, the two words remain ordinary storage and the flags can be ignored.

Each side's pins are sampled on the rising clock edge, and a qualifying operation acts as a single-cycle strobe. An operation made while the acting side's busy input is low has no effect on any flag.

Top module: `mbx_irq`

## Requirements
- R1: After reset, both `lft_irq_n` and `rgt_irq_n` are high.
- R2: The left mailbox is address 0x1FFE (all ones except bit 0). A right-side write to it (`rgt_sel_n`=0, `rgt_rw_n`=0, `rgt_busy_n`=1) drives `lft_irq_n` low from the next rising edge.
- R3: A left-side read of 0x1FFE (`lft_sel_n`=0, `lft_rw_n`=1, `lft_oe_n`=0, `lft_busy_n`=1) returns `lft_irq_n` high from the next edge.
- R4: The right mailbox is address 0x1FFF (all ones). A left-side write to it drives `rgt_irq_n` low from the next edge.
- R5: A right-side read of 0x1FFF, qualified in the same way as R3, returns `rgt_irq_n` high from the next edge.
- R6: A write by a side whose busy input is low leaves the opposite interrupt unchanged.
- R7: A read by a side whose busy input is low leaves its own interrupt unchanged.
- R8: If a set and a clear of the same flag are sampled on the same edge, the flag ends low (set wins).
- R9: A write to one's own mailbox, a read of the other side's mailbox, a read with output enable high, a deselected access, and any other address leave both interrupts unchanged.
- R10: Without a qualifying set or clear, an interrupt holds its level over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both sides are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lft_sel_n | input | 1 | Left select, active low |
| lft_rw_n | input | 1 | Left direction: 1 read, 0 write |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | ADDR_W | Left word address |
| lft_busy_n | input | 1 | Left busy, low blocks left operations |
| rgt_sel_n | input | 1 | Right select, active low |
| rgt_rw_n | input | 1 | Right direction: 1 read, 0 write |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_busy_n | input | 1 | Right busy, low blocks right operations |
| lft_irq_n | output | 1 | Left doorbell interrupt, active low |
| rgt_irq_n | output | 1 | Right doorbell interrupt, active low |

## Verification
The case that is hardest to reach from the ports is a collision: a new message arrives on the same edge as the receiver acknowledges the old one. Reaching it requires two preparations. The flag must already be raised, and both sides must be driven into the same cycle, one writing and one reading the same mailbox. The stimulus first raises the flag with an ordinary write. It then drives both sides together for one edge and checks that the flag is still low. A separate read afterwards shows that the flag still clears normally. Blocking by busy is reached in the same way: the flag is raised first, so that a blocked clear can be seen to have had no effect.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned N_SIDES = 2;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox owned by a side: left gets top-1, right gets top.
  function automatic int unsigned box_addr(int unsigned aw, side_e owner);
    return (32'd1 << aw) - 32'd2 + ((owner == SIDE_R) ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/mbx_side_dec.sv
module mbx_side_dec #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned SEND_ADDR = 8191,
  parameter int unsigned RECV_ADDR = 8190
) (
  input  logic              sel_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output logic              send_stb,
  output logic              recv_stb
);
  localparam logic [ADDR_W-1:0] SEND_A = ADDR_W'(SEND_ADDR);
  localparam logic [ADDR_W-1:0] RECV_A = ADDR_W'(RECV_ADDR);

  logic active;
  logic wr_cyc;
  logic rd_cyc;

  always_comb begin
    active   = !sel_n && busy_n;
    wr_cyc   = active && !rw_n;
    rd_cyc   = active && rw_n && !oe_n;
    send_stb = wr_cyc && (addr == SEND_A);
    recv_stb = rd_cyc && (addr == RECV_A);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_n <= 1'b1;
    else if (set_stb) irq_n <= 1'b0;   // set wins over clear
    else if (clr_stb) irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_sel_n,
  input  logic              lft_rw_n,
  input  logic              lft_oe_n,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              lft_busy_n,
  input  logic              rgt_sel_n,
  input  logic              rgt_rw_n,
  input  logic              rgt_oe_n,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic              rgt_busy_n,
  output logic              lft_irq_n,
  output logic              rgt_irq_n
);
  logic              sel_n  [N_SIDES];
  logic              rw_n   [N_SIDES];
  logic              oe_n   [N_SIDES];
  logic [ADDR_W-1:0] addr   [N_SIDES];
  logic              busy_n [N_SIDES];
  logic              send_stb [N_SIDES];
  logic              recv_stb [N_SIDES];
  logic              irq_n  [N_SIDES];

  always_comb begin
    sel_n[SIDE_L]  = lft_sel_n;  sel_n[SIDE_R]  = rgt_sel_n;
    rw_n[SIDE_L]   = lft_rw_n;   rw_n[SIDE_R]   = rgt_rw_n;
    oe_n[SIDE_L]   = lft_oe_n;   oe_n[SIDE_R]   = rgt_oe_n;
    addr[SIDE_L]   = lft_addr;   addr[SIDE_R]   = rgt_addr;
    busy_n[SIDE_L] = lft_busy_n; busy_n[SIDE_R] = rgt_busy_n;
  end

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    localparam side_e OWN   = side_e'(s);
    localparam side_e OTHER = side_e'(1 - s);

    mbx_side_dec #(
      .ADDR_W   (ADDR_W),
      .SEND_ADDR(box_addr(ADDR_W, OTHER)),
      .RECV_ADDR(box_addr(ADDR_W, OWN))
    ) u_dec (
      .sel_n   (sel_n[s]),
      .rw_n    (rw_n[s]),
      .oe_n    (oe_n[s]),
      .addr    (addr[s]),
      .busy_n  (busy_n[s]),
      .send_stb(send_stb[s]),
      .recv_stb(recv_stb[s])
    );

    // Flag of side s: raised by the other side's send, lowered by own receive.
    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_stb(send_stb[1-s]),
      .clr_stb(recv_stb[s]),
      .irq_n  (irq_n[s])
    );
  end

  assign lft_irq_n = irq_n[SIDE_L];
  assign rgt_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lft_sel_n,
  input logic              lft_rw_n,
  input logic              lft_oe_n,
  input logic [ADDR_W-1:0] lft_addr,
  input logic              lft_busy_n,
  input logic              rgt_sel_n,
  input logic              rgt_rw_n,
  input logic              rgt_oe_n,
  input logic [ADDR_W-1:0] rgt_addr,
  input logic              rgt_busy_n,
  input logic              lft_irq_n,
  input logic              rgt_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

  logic l_set, l_clr, r_set, r_clr;
  assign l_set = !rgt_sel_n && !rgt_rw_n && rgt_busy_n && rgt_addr == BOX_L;
  assign l_clr = !lft_sel_n && lft_rw_n && !lft_oe_n && lft_busy_n && lft_addr == BOX_L;
  assign r_set = !lft_sel_n && !lft_rw_n && lft_busy_n && lft_addr == BOX_R;
  assign r_clr = !rgt_sel_n && rgt_rw_n && !rgt_oe_n && rgt_busy_n && rgt_addr == BOX_R;

  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    l_set |=> !lft_irq_n); // R2
  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (l_clr && !l_set) |=> lft_irq_n); // R3
  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    r_set |=> !rgt_irq_n); // R4
  AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_clr && !r_set) |=> rgt_irq_n); // R5
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_set && !l_clr) |=> $stable(lft_irq_n)); // R10
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_set && !r_clr) |=> $stable(rgt_irq_n)); // R10
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb;
  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] BOX_L = 13'h1FFE;
  localparam logic [AW-1:0] BOX_R = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic lft_sel_n, lft_rw_n, lft_oe_n, lft_busy_n;
  logic rgt_sel_n, rgt_rw_n, rgt_oe_n, rgt_busy_n;
  logic [AW-1:0] lft_addr, rgt_addr;
  logic lft_irq_n, rgt_irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    lft_sel_n = 1; lft_rw_n = 1; lft_oe_n = 1; lft_addr = '0; lft_busy_n = 1;
    rgt_sel_n = 1; rgt_rw_n = 1; rgt_oe_n = 1; rgt_addr = '0; rgt_busy_n = 1;
  endtask

  // One edge with the current drive, then back to idle.
  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic l_op(logic rw, logic oe, logic [AW-1:0] a, logic busy);
    lft_sel_n = 0; lft_rw_n = rw; lft_oe_n = oe; lft_addr = a; lft_busy_n = busy;
  endtask

  task automatic r_op(logic rw, logic oe, logic [AW-1:0] a, logic busy);
    rgt_sel_n = 0; rgt_rw_n = rw; rgt_oe_n = oe; rgt_addr = a; rgt_busy_n = busy;
  endtask

  task automatic t_reset();
    chk("R1 left", lft_irq_n, 1'b1);
    chk("R1 right", rgt_irq_n, 1'b1);
  endtask

  task automatic t_left_box();
    r_op(0, 1, BOX_L, 1); step();
    chk("R2 set", lft_irq_n, 1'b0);
    chk("R2 other", rgt_irq_n, 1'b1);
    repeat (5) step();
    chk("R10 hold", lft_irq_n, 1'b0);
    l_op(1, 1, BOX_L, 1); step();
    chk("R9 oe high", lft_irq_n, 1'b0);
    l_op(1, 0, BOX_R, 1); step();
    chk("R9 wrong box", lft_irq_n, 1'b0);
    l_op(1, 0, BOX_L, 1); step();
    chk("R3 clear", lft_irq_n, 1'b1);
  endtask

  task automatic t_right_box();
    l_op(0, 1, BOX_R, 1); step();
    chk("R4 set", rgt_irq_n, 1'b0);
    chk("R4 other", lft_irq_n, 1'b1);
    repeat (3) step();
    chk("R10 hold right", rgt_irq_n, 1'b0);
    r_op(1, 0, BOX_R, 1); step();
    chk("R5 clear", rgt_irq_n, 1'b1);
  endtask

  task automatic t_busy();
    r_op(0, 1, BOX_L, 0); step();
    chk("R6 blocked set", lft_irq_n, 1'b1);
    r_op(0, 1, BOX_L, 1); step();
    l_op(1, 0, BOX_L, 0); step();
    chk("R7 blocked clear", lft_irq_n, 1'b0);
    l_op(1, 0, BOX_L, 1); step();
    chk("R7 later clear", lft_irq_n, 1'b1);
  endtask

  task automatic t_collide();
    r_op(0, 1, BOX_L, 1); step();
    r_op(0, 1, BOX_L, 1); l_op(1, 0, BOX_L, 1); step();
    chk("R8 set wins", lft_irq_n, 1'b0);
    l_op(1, 0, BOX_L, 1); step();
    chk("R8 then clears", lft_irq_n, 1'b1);
  endtask

  task automatic t_decoys();
    l_op(0, 1, BOX_L, 1); step();
    chk("R9 own box left", lft_irq_n, 1'b1);
    chk("R9 own box right", rgt_irq_n, 1'b1);
    r_op(0, 1, 13'h1FFD, 1); step();
    chk("R9 other address", lft_irq_n, 1'b1);
    r_op(0, 1, BOX_L, 1); rgt_sel_n = 1; step();
    chk("R9 deselected", lft_irq_n, 1'b1);
    r_op(0, 1, BOX_R, 1); step();
    chk("R9 own box right side", rgt_irq_n, 1'b1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_left_box();
    t_right_box();
    t_busy();
    t_collide();
    t_decoys();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule